// File: doc/BRIEF.md
# Decimating Triggered Sample Capture Controller

This block runs one oscilloscope-style acquisition at a time. A supervising controller pulses `start_i`. The block then copies the trigger level and the decimation factor into its own registers and arms. It watches the incoming ADC sample stream for a rising crossing of the level. From the triggering sample onward, it writes one full frame of kept samples into an external sample RAM. The decimation factor sets the time base: only one valid sample in every N is stored.

Once the last sample of the frame has been written, the block walks the RAM read port from the first address to the last. It issues one read in each cycle in which the transmit path is ready, and the transmit path takes the RAM output one cycle later. After the final read, the block raises a one-cycle completion pulse and returns to idle.

Top module: `dcap_ctrl`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `wr_en_o` and `rd_en_o` are all low, whatever the sample, valid and ready inputs do.
- R2: A start pulse is accepted only in the idle state. A start during an acquisition has no effect: that acquisition still writes exactly FRAME samples with the expected values and ends with a single done pulse.
- R3: The trigger level and decimation factor are sampled in the cycle a start is accepted. Changing `trig_level_i` or `decim_i` later does not alter the running acquisition.
- R4: The trigger fires on a valid sample that is at or above the level when the previous valid sample since arming was below it. The first valid sample after arming never triggers, and cycles with `smp_valid_i` low are skipped entirely.
- R5: The triggering sample is the first sample written, and it goes to address 0.
- R6: Counting valid samples after the trigger as k = 1, 2, …, sample k is written if and only if k mod N = 0. A factor of 0 acts as 1, which keeps every sample.
- R7: Write addresses run 0, 1, …, FRAME-1 with one address per write. No write occurs after address FRAME-1.
- R8: Reads start only after the frame is complete. They present addresses 0 to FRAME-1 in order, one in each cycle with `tx_ready_i` high. `rd_en_o` is never high while `tx_ready_i` is low.
- R9: `busy_o` is high from the cycle after a start is accepted until the final read. In the cycle after the final read, `done_o` is high for exactly one cycle while `busy_o` is low.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse from the supervising controller |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | DW | Unsigned ADC sample |
| trig_level_i | input | DW | Trigger level |
| decim_i | input | DECW | Decimation factor (0 acts as 1) |
| tx_ready_i | input | 1 | Transmit path can accept a sample |
| wr_en_o | output | 1 | RAM write enable |
| wr_addr_o | output | AW | RAM write address |
| wr_data_o | output | DW | RAM write data |
| rd_en_o | output | 1 | RAM read enable |
| rd_addr_o | output | AW | RAM read address |
| busy_o | output | 1 | Acquisition in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every decimation factor from 0 to 5 against three trigger levels. Some of these levels equal sample values, so a design that used a strict comparison would trigger late and store the wrong first sample. Invalid-sample gaps are mixed into the stream. A design that advanced its trigger history or its decimation count on those gaps would store the wrong samples. Factor 0 exposes a design that divides by the raw value.

Mid-run changes to the configuration and extra start pulses catch a design that fails to latch its settings or that re-arms while busy. Both faults show up as wrong write data or a second done pulse. A ready signal that stalls in a pattern checks that reads follow `tx_ready_i` and keep their order. Watching for the last write checks that the frame stops at exactly FRAME samples.

// File: rtl/dcap_pkg.sv
package dcap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_CAPTURE,
    ST_READOUT,
    ST_DONE
  } dcap_state_e;
endpackage

// File: rtl/dcap_trig.sv
module dcap_trig #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [DW-1:0] smp,
  input  logic [DW-1:0] level,
  output logic          fire
);
  logic [DW-1:0] prev_q;
  logic          have_q;

  assign fire = en && have_q && (prev_q < level) && (smp >= level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (clr) begin
      have_q <= 1'b0;
    end else if (en) begin
      prev_q <= smp;
      have_q <= 1'b1;
    end
  end

  // R4: a crossing needs a valid sample seen since arming
  a_r4_history_first: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !fire);
endmodule

// File: rtl/dcap_decim.sv
module dcap_decim #(
  parameter int DECW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            step,
  input  logic [DECW-1:0] factor,
  output logic            keep
);
  logic [DECW-1:0] cnt_q;
  logic [DECW-1:0] cnt_d;
  logic [DECW-1:0] fe;

  assign fe   = (factor == '0) ? DECW'(1) : factor;
  assign keep = step && (cnt_q == fe - DECW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (keep) cnt_d = '0;
    else if (step) cnt_d = cnt_q + DECW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: the phase counter never passes the factor while stepping
  a_r6_cnt_below_factor: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> cnt_q < fe);
endmodule

// File: rtl/dcap_ctrl.sv
module dcap_ctrl
  import dcap_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DECW  = 4,
  parameter int FRAME = 1024,
  localparam int AW   = (FRAME > 1) ? $clog2(FRAME) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            smp_valid_i,
  input  logic [DW-1:0]   smp_data_i,
  input  logic [DW-1:0]   trig_level_i,
  input  logic [DECW-1:0] decim_i,
  input  logic            tx_ready_i,
  output logic            wr_en_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [DW-1:0]   wr_data_o,
  output logic            rd_en_o,
  output logic [AW-1:0]   rd_addr_o,
  output logic            busy_o,
  output logic            done_o
);
  localparam logic [AW-1:0] LAST = AW'(FRAME - 1);

  dcap_state_e     st_q, st_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [DW-1:0]   lvl_q;
  logic [DECW-1:0] dec_q;
  logic            cfg_ld;
  logic            fire, keep;

  dcap_trig #(.DW(DW)) i_trig (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_ld),
    .en    (st_q == ST_ARMED && smp_valid_i),
    .smp   (smp_data_i),
    .level (lvl_q),
    .fire  (fire)
  );

  dcap_decim #(.DECW(DECW)) i_decim (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (fire),
    .step    (st_q == ST_CAPTURE && smp_valid_i),
    .factor  (dec_q),
    .keep    (keep)
  );

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    cfg_ld  = 1'b0;
    wr_en_o = 1'b0;
    rd_en_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d   = ST_ARMED;
        cfg_ld = 1'b1;
        addr_d = '0;
      end
      ST_ARMED, ST_CAPTURE: if ((st_q == ST_ARMED) ? fire : keep) begin
        wr_en_o = 1'b1;
        if (addr_q == LAST) begin
          st_d   = ST_READOUT;
          addr_d = '0;
        end else begin
          st_d   = ST_CAPTURE;
          addr_d = addr_q + AW'(1);
        end
      end
      ST_READOUT: if (tx_ready_i) begin
        rd_en_o = 1'b1;
        if (addr_q == LAST) begin
          st_d   = ST_DONE;
          addr_d = '0;
        end else begin
          addr_d = addr_q + AW'(1);
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      dec_q <= '0;
    end else if (cfg_ld) begin
      lvl_q <= trig_level_i;
      dec_q <= decim_i;
    end
  end

  assign wr_addr_o = addr_q;
  assign wr_data_o = smp_data_i;
  assign rd_addr_o = addr_q;
  assign busy_o    = (st_q == ST_ARMED) || (st_q == ST_CAPTURE) || (st_q == ST_READOUT);
  assign done_o    = (st_q == ST_DONE);

  // R2: no re-arming once capture or readout is under way
  a_r2_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CAPTURE || st_q == ST_READOUT || st_q == ST_DONE) |=> st_q != ST_ARMED);
  // R8: a read is only issued toward a ready transmitter
  a_r8_rd_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> tx_ready_i);
  // R8: reads and writes never overlap
  a_r8_rd_wr_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_o && wr_en_o));
  // R9: completion lasts one cycle and follows the final read
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(rd_en_o));
endmodule

// File: tb/test_dcap_ctrl.sv
module test_dcap_ctrl;
  localparam int DW = 8, DECW = 4, FRAME = 8, AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, smp_valid_i = 1'b0, tx_ready_i = 1'b0;
  logic [DW-1:0] smp_data_i = '0, trig_level_i = '0;
  logic [DECW-1:0] decim_i = '0;
  logic wr_en_o, rd_en_o, busy_o, done_o;
  logic [AW-1:0] wr_addr_o, rd_addr_o;
  logic [DW-1:0] wr_data_o;

  int checks = 0, errors = 0;
  int exp_q [FRAME];

  always #10 clk = ~clk;

  dcap_ctrl #(.DW(DW), .DECW(DECW), .FRAME(FRAME)) i_dcap_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .smp_valid_i(smp_valid_i),
    .smp_data_i(smp_data_i), .trig_level_i(trig_level_i), .decim_i(decim_i),
    .tx_ready_i(tx_ready_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int smp_at(input int i, input int seed);
    return (i * 11 + seed) % 64;
  endfunction

  function automatic bit vld_at(input int i);
    return (i % 4) != 3;
  endfunction

  // Reference: R4 crossing, R5 first write, R6 keep when k mod N == 0
  task automatic build_exp(input int seed, input int lvl, input int fac);
    int fe, n, k, prev;
    bit have, trig;
    fe = (fac == 0) ? 1 : fac;
    n = 0; k = 0; prev = 0; have = 0; trig = 0;
    for (int i = 0; i < 5000 && n < FRAME; i++) begin
      if (vld_at(i)) begin
        if (!trig) begin
          if (have && prev < lvl && smp_at(i, seed) >= lvl) begin
            trig = 1; exp_q[n] = smp_at(i, seed); n++; k = 0;
          end else begin
            prev = smp_at(i, seed); have = 1;
          end
        end else begin
          k++;
          if (k % fe == 0) begin exp_q[n] = smp_at(i, seed); n++; end
        end
      end
    end
  endtask

  task automatic run(input int seed, input int lvl, input int fac);
    int wcnt, rcnt, dones;
    bit fin;
    build_exp(seed, lvl, fac);
    @(negedge clk);
    trig_level_i = DW'(lvl); decim_i = DECW'(fac); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after start", int'(busy_o), 1);
    wcnt = 0; rcnt = 0; dones = 0; fin = 0;
    for (int i = 0; i < 3000 && !fin; i++) begin
      smp_valid_i = vld_at(i);
      smp_data_i  = DW'(smp_at(i, seed));
      tx_ready_i  = (i % 3) != 2;
      if (i == 2) begin trig_level_i = 8'd0; decim_i = DECW'(fac + 3); end
      start_i = (i == 4) || (i % 37 == 20);
      #1;
      if (wr_en_o) begin
        chk(wcnt < FRAME, "R7 no write past frame", wcnt, FRAME - 1);
        if (wcnt < FRAME) begin
          chk(int'(wr_addr_o) == wcnt, "R7 write address", int'(wr_addr_o), wcnt);
          chk(int'(wr_data_o) == exp_q[wcnt],
              (wcnt == 0) ? "R5 trigger sample" : "R6 R3 kept sample",
              int'(wr_data_o), exp_q[wcnt]);
        end
        wcnt++;
      end
      if (rd_en_o) begin
        chk(wcnt == FRAME, "R8 read after full frame", wcnt, FRAME);
        chk(tx_ready_i == 1'b1, "R8 read needs ready", int'(tx_ready_i), 1);
        chk(int'(rd_addr_o) == rcnt, "R8 read order", int'(rd_addr_o), rcnt);
        rcnt++;
      end
      if (done_o) begin
        dones++;
        chk(rcnt == FRAME, "R9 done after last read", rcnt, FRAME);
        chk(busy_o == 1'b0, "R9 busy low at done", int'(busy_o), 0);
        fin = 1;
      end else if (!fin) begin
        chk(busy_o == 1'b1, "R9 busy during run", int'(busy_o), 1);
      end
      @(negedge clk);
    end
    start_i = 1'b0; smp_valid_i = 1'b0;
    chk(fin, "R9 acquisition completed", int'(fin), 1);
    chk(dones == 1, "R2 single done", dones, 1);
    #1;
    chk(done_o == 1'b0 && busy_o == 1'b0, "R9 R2 idle after done",
        int'(done_o) + int'(busy_o), 0);
    chk(wcnt == FRAME && rcnt == FRAME, "R7 R8 counts", wcnt + rcnt, 2 * FRAME);
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    smp_valid_i = 1'b1; tx_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      smp_data_i = DW'(i * 40);
      #1;
      chk(!busy_o && !done_o && !wr_en_o && !rd_en_o, "R1 reset idle",
          int'(busy_o) + int'(done_o) + int'(wr_en_o) + int'(rd_en_o), 0);
      @(negedge clk);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      smp_data_i = DW'(i * 40);
      #1;
      chk(!busy_o && !wr_en_o && !rd_en_o, "R1 idle without start",
          int'(busy_o) + int'(wr_en_o) + int'(rd_en_o), 0);
      @(negedge clk);
    end
    smp_valid_i = 1'b0;
    for (int f = 0; f <= 5; f++) begin
      run(f * 5, 10, f);   // R4 R6 sweep
      run(f * 7 + 1, 33, f);
      run(f * 3 + 2, 60, f);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule